// File: doc/BRIEF.md
# Horizontal Windowed Row Summer

This block slides a horizontal window across a stream of image rows. Each row arrives as WORDS words of LANES lanes. Each word carries three parallel lane vectors: per-pixel column sums, column sums of squares, and valid-pixel counts. For every pixel the block returns, on each of the three vectors, the total over the 2*NBX+1 columns centred on that pixel. A window that would reach past the first or last column of a row is cut short at the row edge, so edge pixels total fewer columns. When this block is placed after a vertical column summer, the results are the totals over a full square neighbourhood.

A pixel near the upper end of a word needs lanes from the next word. The core therefore finishes a word only when the following word arrives. After the last word of a row it spends one drain cycle, with in_ready low, to finish that word. For each row the core produces one more beat than the row has words, and the first of these beats is a dummy. An alignment stage drops the dummy, so exactly WORDS output beats leave per row, in column order.

The control is a three-state machine. S_HEAD waits for the first word of a row; accepting it goes to S_BODY, or to S_DRAIN if the row has one word. S_BODY accepts words and goes to S_DRAIN on the last word of the row. S_DRAIN lasts one cycle, holds in_ready low, emits the last word, and returns to S_HEAD unconditionally.

Top module: `hwin_summer`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: For a column c with NBX <= c <= COLS-1-NBX, the output on every stream is the sum of input columns c-NBX through c+NBX. Sums wrap modulo 2^W of the stream's lane width, so negative two's-complement sums are exact.
- R3: For a column c < NBX, the window is clipped to columns 0 through c+NBX. Column 0 therefore covers NBX+1 values.
- R4: For a column c > COLS-1-NBX, the window is clipped to columns c-NBX through COLS-1. The last column therefore covers NBX+1 values.
- R5: Windows of lanes near either end of a word include lanes of the neighbouring word. Lane l of word w is column w*LANES+l, and lane 0 is the least significant field of the word.
- R6: The count stream uses the same clipping. With every input count 1, the outputs are NBX+1 at column 0, NBX+2 at column 1, NBX+2 at column COLS-2 and NBX+1 at column COLS-1. A zero count is not counted.
- R7: The squares stream is windowed on its own wider, unsigned lanes. Its values do not affect the other streams.
- R8: Each row gives exactly WORDS output beats in column order. A beat appears two cycles after the cycle that accepts the next word of the row, or after the drain cycle for the last word.
- R9: After the last word of a row is accepted, in_ready is low for exactly one cycle. It is never low at any other time.
- R10: Rows are independent. When a row follows the previous one directly, its first columns contain nothing from the previous row.
- R11: Idle cycles with in_valid low between the words of a row do not change any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Word is accepted when in_valid and in_ready are both high; low during the drain cycle |
| in_sum | input | LANES*SUM_W | Column sums, lane l at bits l*SUM_W upward |
| in_sq | input | LANES*SQ_W | Column sums of squares, unsigned |
| in_cnt | input | LANES*CNT_W | Valid-pixel counts per column |
| out_valid | output | 1 | Windowed output word present |
| out_sum | output | LANES*SUM_W | Windowed sums |
| out_sq | output | LANES*SQ_W | Windowed sums of squares |
| out_cnt | output | LANES*CNT_W | Windowed valid counts |

## Verification
The assertions check the handshake and beat framing on every cycle:
- the drain cycle follows each last word, and only that word, and lasts exactly one cycle;
- every output beat traces back two cycles to an accepted word or to a drain cycle;
- the number of words accepted but not yet returned stays within its bound.

The arithmetic can only be shown by the bench's scenarios, which compare lane values against a model of the clipped window. These cover the edge clipping on each stream, windows that span a word boundary, negative sums, rows that follow each other directly, and rows broken up by idle cycles.

// File: rtl/hwin_pkg.sv
package hwin_pkg;
    typedef enum logic [1:0] {
        S_HEAD  = 2'd0,
        S_BODY  = 2'd1,
        S_DRAIN = 2'd2
    } hwin_state_e;
endpackage

// File: rtl/hwin_ctrl.sv
module hwin_ctrl
    import hwin_pkg::*;
#(
    parameter int WORDS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic in_ready,
    output logic take,
    output logic head,
    output logic drain
);
    localparam int CW = (WORDS > 1) ? $clog2(WORDS) : 1;

    hwin_state_e state, nxt;
    logic [CW-1:0] widx;
    logic          last;

    assign last = (widx == CW'(WORDS - 1));

    // state register and word position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_HEAD;
            widx  <= '0;
        end else begin
            state <= nxt;
            if (take) widx <= last ? '0 : widx + 1'b1;
        end
    end

    // next state and outputs
    always_comb begin
        nxt      = state;
        in_ready = 1'b1;
        take     = 1'b0;
        head     = 1'b0;
        drain    = 1'b0;
        unique case (state)
            S_HEAD: begin
                head = 1'b1;
                take = in_valid;
                if (in_valid) nxt = last ? S_DRAIN : S_BODY;
            end
            S_BODY: begin
                take = in_valid;
                if (in_valid && last) nxt = S_DRAIN;
            end
            S_DRAIN: begin
                in_ready = 1'b0;
                drain    = 1'b1;
                nxt      = S_HEAD;
            end
            default: nxt = S_HEAD;
        endcase
    end
endmodule

// File: rtl/hwin_window.sv
module hwin_window #(
    parameter int W     = 20,
    parameter int LANES = 32,
    parameter int NBX   = 2
) (
    input  logic [(LANES+2*NBX)*W-1:0] ext,
    output logic [LANES*W-1:0]         win
);
    localparam int EL   = LANES + 2 * NBX;
    localparam int SPAN = 2 * NBX + 1;

    logic [W-1:0] pre [0:EL];

    always_comb begin
        pre[0] = '0;
        for (int i = 0; i < EL; i++)
            pre[i+1] = pre[i] + ext[i*W +: W];
    end

    genvar k;
    generate
        for (k = 0; k < LANES; k++) begin : g_out
            assign win[k*W +: W] = pre[k+SPAN] - pre[k];
        end
    endgenerate
endmodule

// File: rtl/hwin_lane.sv
module hwin_lane #(
    parameter int W     = 20,
    parameter int LANES = 32,
    parameter int NBX   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take,
    input  logic               head,
    input  logic               drain,
    input  logic [LANES*W-1:0] in_word,
    output logic [LANES*W-1:0] core_word
);
    localparam int HW = NBX * W;

    logic [LANES*W-1:0]         center;
    logic [HW-1:0]              lhalo;
    logic [HW-1:0]              rhalo;
    logic [(LANES+2*NBX)*W-1:0] ext;
    logic [LANES*W-1:0]         win;

    assign rhalo = drain ? '0 : in_word[HW-1:0];
    assign ext   = {rhalo, center, lhalo};

    hwin_window #(.W(W), .LANES(LANES), .NBX(NBX)) u_win (
        .ext (ext),
        .win (win)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            center    <= '0;
            lhalo     <= '0;
            core_word <= '0;
        end else begin
            if (take) begin
                center <= in_word;
                lhalo  <= head ? '0 : center[LANES*W-1 -: HW];
            end
            if (take || drain) core_word <= win;
        end
    end
endmodule

// File: rtl/hwin_align.sv
module hwin_align #(
    parameter int D = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         core_vld,
    input  logic         core_dummy,
    input  logic [D-1:0] core_data,
    output logic         out_valid,
    output logic [D-1:0] out_data
);
    logic keep;
    assign keep = core_vld && !core_dummy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= keep;
            if (keep) out_data <= core_data;
        end
    end
endmodule

// File: rtl/hwin_summer.sv
module hwin_summer #(
    parameter int LANES = 32,
    parameter int WORDS = 32,
    parameter int NBX   = 2,
    parameter int SUM_W = 20,
    parameter int SQ_W  = 36,
    parameter int CNT_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [LANES*SUM_W-1:0] in_sum,
    input  logic [LANES*SQ_W-1:0]  in_sq,
    input  logic [LANES*CNT_W-1:0] in_cnt,
    output logic                   out_valid,
    output logic [LANES*SUM_W-1:0] out_sum,
    output logic [LANES*SQ_W-1:0]  out_sq,
    output logic [LANES*CNT_W-1:0] out_cnt
);
    localparam int DS = LANES * SUM_W;
    localparam int DQ = LANES * SQ_W;
    localparam int DC = LANES * CNT_W;
    localparam int D  = DS + DQ + DC;

    logic take, head, drain;
    logic core_vld, core_dummy;
    logic [DS-1:0] c_sum;
    logic [DQ-1:0] c_sq;
    logic [DC-1:0] c_cnt;
    logic [D-1:0]  o_data;

    hwin_ctrl #(.WORDS(WORDS)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .take     (take),
        .head     (head),
        .drain    (drain)
    );

    hwin_lane #(.W(SUM_W), .LANES(LANES), .NBX(NBX)) u_sum (
        .clk(clk), .rst_n(rst_n), .take(take), .head(head), .drain(drain),
        .in_word(in_sum), .core_word(c_sum)
    );

    hwin_lane #(.W(SQ_W), .LANES(LANES), .NBX(NBX)) u_sq (
        .clk(clk), .rst_n(rst_n), .take(take), .head(head), .drain(drain),
        .in_word(in_sq), .core_word(c_sq)
    );

    hwin_lane #(.W(CNT_W), .LANES(LANES), .NBX(NBX)) u_cnt (
        .clk(clk), .rst_n(rst_n), .take(take), .head(head), .drain(drain),
        .in_word(in_cnt), .core_word(c_cnt)
    );

    // core beat flags: the beat from the first word of a row is the dummy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_vld   <= 1'b0;
            core_dummy <= 1'b0;
        end else begin
            core_vld   <= take || drain;
            core_dummy <= take && head;
        end
    end

    hwin_align #(.D(D)) u_align (
        .clk        (clk),
        .rst_n      (rst_n),
        .core_vld   (core_vld),
        .core_dummy (core_dummy),
        .core_data  ({c_cnt, c_sq, c_sum}),
        .out_valid  (out_valid),
        .out_data   (o_data)
    );

    assign out_sum = o_data[DS-1:0];
    assign out_sq  = o_data[DS +: DQ];
    assign out_cnt = o_data[DS+DQ +: DC];
endmodule

// File: rtl/hwin_summer_chk.sv
module hwin_summer_chk #(
    parameter int WORDS = 32
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic out_valid
);
    localparam int CW = (WORDS > 1) ? $clog2(WORDS) : 1;

    logic          acc;
    logic [CW-1:0] pos;
    logic [7:0]    pending;

    assign acc = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos     <= '0;
            pending <= '0;
        end else begin
            if (acc) pos <= (pos == CW'(WORDS - 1)) ? '0 : pos + 1'b1;
            pending <= pending + {7'd0, acc} - {7'd0, out_valid};
        end
    end

    AST_DRAIN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> in_ready); // R9
    AST_DRAIN_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && pos == CW'(WORDS - 1)) |=> !in_ready); // R9
    AST_NO_EARLY_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && pos != CW'(WORDS - 1)) |=> in_ready); // R9
    AST_OUT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(acc || !in_ready, 2)); // R8
    AST_PENDING_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pending <= 8'd3); // R8
    AST_NO_OUT_UNFED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> pending != 8'd0); // R8
endmodule

bind hwin_summer hwin_summer_chk #(.WORDS(WORDS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid)
);

// File: tb/test_hwin_summer.sv
`timescale 1ns/1ps
module test_hwin_summer;
    localparam int LANES = 32;
    localparam int WORDS = 32;
    localparam int NBX   = 2;
    localparam int SUM_W = 20;
    localparam int SQ_W  = 36;
    localparam int CNT_W = 8;
    localparam int COLS  = LANES * WORDS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready, out_valid;
    logic [LANES*SUM_W-1:0] in_sum = '0, out_sum;
    logic [LANES*SQ_W-1:0]  in_sq  = '0, out_sq;
    logic [LANES*CNT_W-1:0] in_cnt = '0, out_cnt;

    always #5 clk = ~clk;

    hwin_summer #(.LANES(LANES), .WORDS(WORDS), .NBX(NBX),
                  .SUM_W(SUM_W), .SQ_W(SQ_W), .CNT_W(CNT_W)) i_hwin_summer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_sum(in_sum), .in_sq(in_sq), .in_cnt(in_cnt),
        .out_valid(out_valid), .out_sum(out_sum), .out_sq(out_sq), .out_cnt(out_cnt)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    longint vs [0:2*COLS-1];
    longint vq [0:2*COLS-1];
    longint vc [0:2*COLS-1];
    longint gs [0:2*COLS-1];
    longint gq [0:2*COLS-1];
    longint gc [0:2*COLS-1];
    int oidx = 0;

    // collect output beats away from the active edge
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            for (int l = 0; l < LANES; l++) begin
                if (oidx*LANES + l < 2*COLS) begin
                    gs[oidx*LANES+l] = longint'($signed(out_sum[l*SUM_W +: SUM_W]));
                    gq[oidx*LANES+l] = longint'(out_sq[l*SQ_W +: SQ_W]);
                    gc[oidx*LANES+l] = longint'(out_cnt[l*CNT_W +: CNT_W]);
                end
            end
            oidx++;
        end
    end

    task automatic chk(input string req, input longint got, input longint exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, got, exp);
        end
    endtask

    // model: clipped window within row r; which 0=sum 1=sq 2=cnt
    function automatic longint wsum(int which, int r, int c);
        longint s = 0;
        int lo = (c - NBX < 0) ? 0 : c - NBX;
        int hi = (c + NBX > COLS - 1) ? COLS - 1 : c + NBX;
        for (int j = lo; j <= hi; j++) begin
            if (which == 0) s += vs[r*COLS+j];
            else if (which == 1) s += vq[r*COLS+j];
            else s += vc[r*COLS+j];
        end
        if (which == 0) begin
            s = s & ((64'd1 << SUM_W) - 1);
            if (s >= (64'd1 << (SUM_W-1))) s -= (64'd1 << SUM_W);
        end else if (which == 1) s = s & ((64'd1 << SQ_W) - 1);
        else s = s & ((64'd1 << CNT_W) - 1);
        return s;
    endfunction

    task automatic send_word(input int r, input int w, input int gap);
        repeat (gap) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
        @(negedge clk);
        in_valid = 1'b0;
        while (!in_ready) @(negedge clk);
        for (int l = 0; l < LANES; l++) begin
            in_sum[l*SUM_W +: SUM_W] = vs[r*COLS + w*LANES + l][SUM_W-1:0];
            in_sq[l*SQ_W +: SQ_W]    = vq[r*COLS + w*LANES + l][SQ_W-1:0];
            in_cnt[l*CNT_W +: CNT_W] = vc[r*COLS + w*LANES + l][CNT_W-1:0];
        end
        in_valid = 1'b1;
    endtask

    task automatic send_row(input int r, input int gapmod, input bit chk_drain);
        for (int w = 0; w < WORDS; w++)
            send_word(r, w, (gapmod > 0 && (w % gapmod) == 1) ? 2 : 0);
        if (chk_drain) begin
            @(negedge clk);
            in_valid = 1'b0;
            chk("R9 in_ready low after last word", longint'(in_ready), 0);
            @(negedge clk);
            chk("R9 in_ready back high", longint'(in_ready), 1);
        end
    endtask

    task automatic finish_row();
        @(negedge clk);
        in_valid = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic compare_row(input string req, input int r, input int ofs);
        int bad_s = 0, bad_q = 0, bad_c = 0;
        for (int c = 0; c < COLS; c++) begin
            if (gs[ofs+c] != wsum(0, r, c)) bad_s++;
            if (gq[ofs+c] != wsum(1, r, c)) bad_q++;
            if (gc[ofs+c] != wsum(2, r, c)) bad_c++;
        end
        chk({req, " sum mismatches"}, bad_s, 0);
        chk({req, " sq mismatches"}, bad_q, 0);
        chk({req, " cnt mismatches"}, bad_c, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 out_valid after reset", longint'(out_valid), 0);
        chk("R1 in_ready after reset", longint'(in_ready), 1);
    endtask

    task automatic t_ramp();
        for (int c = 0; c < COLS; c++) begin
            vs[c] = c; vq[c] = 8934 + c; vc[c] = 1;
        end
        oidx = 0;
        send_row(0, 0, 1'b1);
        finish_row();
        chk("R8 beats per row", oidx, WORDS);
        chk("R3 sum col 0", gs[0], (NBX + 1) * NBX / 2);
        chk("R3 sum col 1", gs[1], wsum(0, 0, 1));
        chk("R2 sum col NBX+5", gs[NBX+5], (2*NBX + 1) * (NBX + 5));
        chk("R4 sum last col", gs[COLS-1], wsum(0, 0, COLS-1));
        chk("R5 sum col 31 across word", gs[LANES-1], (2*NBX + 1) * (LANES - 1));
        chk("R5 sum col 32 across word", gs[LANES], (2*NBX + 1) * LANES);
        chk("R6 cnt col 0", gc[0], NBX + 1);
        chk("R6 cnt col 1", gc[1], NBX + 2);
        chk("R6 cnt col COLS-2", gc[COLS-2], NBX + 2);
        chk("R6 cnt col COLS-1", gc[COLS-1], NBX + 1);
        chk("R6 cnt interior", gc[500], 2*NBX + 1);
        chk("R7 sq col 0", gq[0], wsum(1, 0, 0));
        chk("R7 sq interior", gq[700], wsum(1, 0, 700));
        compare_row("R2 ramp", 0, 0);
    endtask

    task automatic t_gaps_signed();
        for (int c = 0; c < COLS; c++) begin
            vs[c] = (c % 7) * -37 + (c % 3);
            vq[c] = 64'd40000000000 + c * 13;
            vc[c] = ((c % 5) == 0) ? 0 : 1;
        end
        oidx = 0;
        send_row(0, 3, 1'b0);
        finish_row();
        chk("R11 beats per gapped row", oidx, WORDS);
        chk("R2 negative interior sum", gs[100], wsum(0, 0, 100));
        chk("R6 cnt with zero counts", gc[10], wsum(2, 0, 10));
        compare_row("R11 gapped", 0, 0);
    endtask

    task automatic t_back_to_back();
        for (int c = 0; c < COLS; c++) begin
            vs[c] = 500; vq[c] = 9000; vc[c] = 1;
            vs[COLS+c] = c; vq[COLS+c] = 3 * c; vc[COLS+c] = 1;
        end
        oidx = 0;
        send_row(0, 0, 1'b0);
        send_row(1, 0, 1'b0);
        finish_row();
        chk("R8 beats for two rows", oidx, 2 * WORDS);
        chk("R10 row 1 last col", gs[COLS-1], 500 * (NBX + 1));
        chk("R10 row 2 col 0", gs[COLS], wsum(0, 1, 0));
        chk("R10 row 2 cnt col 0", gc[COLS], NBX + 1);
        compare_row("R10 second row", 1, COLS);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ramp();
        t_gaps_signed();
        t_back_to_back();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule